// File: doc/BRIEF.md
# PLL Reference and Feedback Dividers

This block holds the two programmable counters of a frequency-synthesis loop. The analog parts are not in it. One counter divides reference cycles by Q+2. The other divides oscillator-rate cycles by 2·(PB+4)+PO. Both counters run on a single system clock, and each one advances only in cycles where its own tick input is high. Each counter reports the end of every divided period with a one-cycle pulse, which a phase detector downstream consumes.

The ratios come from three 8-bit configuration registers. A simple write port loads them, and a combinational read port returns them.

- Selector 0 holds the charge-pump code and the two top PB bits.
- Selector 1 holds the low eight PB bits.
- Selector 2 holds PO and Q.

The block compares the pump code with the code that the current feedback total requires, and raises an error flag on any mismatch.

Top module: `pll_div_core`

## Requirements
- R1: The reference ratio is Q+2. Q is bits 6:0 of the selector-2 register, so the ratio covers 2 to 129. With `ref_tick_i` held high, `ref_pulse_o` repeats every Q+2 clock cycles.
- R2: The feedback ratio is 2·(PB+4)+PO, covering 8 to 2055.
  - PB[9:8] are bits 1:0 of the selector-0 register, and PB[7:0] are the selector-1 register.
  - PO is bit 7 of the selector-2 register.
  - With `fb_tick_i` held high, `fb_pulse_o` repeats every ratio clock cycles.
- R3: Each divider counts only cycles whose tick input is high. When such a cycle ends the count, the divider gives a pulse exactly one clock cycle wide, in the next cycle. No pulse appears without a tick in the cycle before.
- R4: A ratio written while a period is running does not change that period. It takes effect from the next terminal count onward.
- R5: The pump code is bits 4:2 of the selector-0 register. Bits 7:5 of that register always read back as 110, whatever was written there.
- R6: For feedback totals from 16 to 1023, `err_o` is high exactly when the pump code differs from the required code. The required code is:
  - 000 for 16 to 44;
  - 001 for 45 to 479;
  - 010 for 480 to 639;
  - 011 for 640 to 799;
  - 100 for 800 to 1023.
- R7: `err_o` is high whenever the pump code is 101, 110 or 111. It is also high whenever the feedback total is below 16 or above 1023.
- R8: Reset has the following effects:
  - Both counters clear, both pulse outputs go low, and the registers take their reset values (PB=4, PO=0, Q=0, pump code 000, giving totals 16 and 2).
  - `err_o` follows from those reset values.
  - The first tick after reset produces a pulse.
- R9: The read port is combinational. Selector 1 returns PB[7:0], selector 2 returns {PO, Q}, and selector 3 returns 0. A register write is visible on the read port and on `err_o` from the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register selector for writes |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Register selector for reads |
| rd_data_o | output | 8 | Read data |
| ref_tick_i | input | 1 | Reference input cycle marker |
| fb_tick_i | input | 1 | Oscillator-rate input cycle marker |
| ref_pulse_o | output | 1 | Divided reference pulse |
| fb_pulse_o | output | 1 | Divided feedback pulse |
| err_o | output | 1 | Pump code does not fit the feedback total |

## Verification
Both dividers are run at their extreme ratios: 2 and 129 on the reference side, 8 and 2055 on the feedback side. They are also run at an odd feedback ratio, which shows that PO lands in the lowest bit of the modulus and that PB is packed in the right place.

A tick held high is compared against a tick that is high every other cycle. This separates counting clock cycles from counting enabled cycles.

A ratio change written in the middle of a period must leave that period intact and apply to the one after.

The error flag is tried at both sides of every range edge of the pump table (44/45, 479/480, 639/640, 799/800, 1023/1024), at a total below 16, and with an illegal code. These cases separate an off-by-one range boundary from a correct one.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned Q_W    = 7;
  localparam int unsigned PB_W   = 10;
  localparam int unsigned PUMP_W = 3;
  localparam int unsigned REF_W  = Q_W + 1;
  localparam int unsigned FB_W   = PB_W + 2;
  localparam int unsigned FB_MIN = 16;
  localparam int unsigned FB_MAX = 1023;
  localparam logic [2:0]  CTL_FIXED = 3'b110;
  localparam logic [PUMP_W-1:0] PUMP_MAX = 3'd4;

  typedef enum logic [1:0] {
    SEL_CTL = 2'd0,
    SEL_PBL = 2'd1,
    SEL_PQ  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // pump code demanded by a feedback total inside FB_MIN..FB_MAX
  function automatic logic [PUMP_W-1:0] pump_need(input logic [FB_W-1:0] tot);
    if (tot <= FB_W'(44))       return 3'd0;
    else if (tot <= FB_W'(479)) return 3'd1;
    else if (tot <= FB_W'(639)) return 3'd2;
    else if (tot <= FB_W'(799)) return 3'd3;
    else                        return 3'd4;
  endfunction
endpackage

// File: rtl/pll_div_regs.sv
module pll_div_regs
  import pll_div_pkg::*;
#(
  parameter logic [PB_W-1:0]   RST_PB   = 10'd4,
  parameter logic              RST_PO   = 1'b0,
  parameter logic [Q_W-1:0]    RST_Q    = 7'd0,
  parameter logic [PUMP_W-1:0] RST_PUMP = 3'd0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [PB_W-1:0]  pb_o,
  output logic             po_o,
  output logic [Q_W-1:0]   q_o,
  output logic [PUMP_W-1:0] pump_o
);
  localparam int unsigned CTL_W = PUMP_W + PB_W - REG_W;

  logic [CTL_W-1:0] ctl_q;
  logic [REG_W-1:0] pbl_q;
  logic [REG_W-1:0] pq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= {RST_PUMP, RST_PB[PB_W-1:REG_W]};
      pbl_q <= RST_PB[REG_W-1:0];
      pq_q  <= {RST_PO, RST_Q};
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(wr_sel_i))
        SEL_CTL: ctl_q <= wr_data_i[CTL_W-1:0];
        SEL_PBL: pbl_q <= wr_data_i;
        SEL_PQ:  pq_q  <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_sel_e'(rd_sel_i))
      SEL_CTL: rd_data_o = {CTL_FIXED, ctl_q};
      SEL_PBL: rd_data_o = pbl_q;
      SEL_PQ:  rd_data_o = pq_q;
      default: rd_data_o = '0;
    endcase
  end

  assign pb_o   = {ctl_q[PB_W-REG_W-1:0], pbl_q};
  assign pump_o = ctl_q[CTL_W-1:PB_W-REG_W];
  assign po_o   = pq_q[REG_W-1];
  assign q_o    = pq_q[Q_W-1:0];
endmodule

// File: rtl/pll_div_decode.sv
module pll_div_decode
  import pll_div_pkg::*;
(
  input  logic [PB_W-1:0]   pb_i,
  input  logic              po_i,
  input  logic [Q_W-1:0]    q_i,
  input  logic [PUMP_W-1:0] pump_i,
  output logic [REF_W-1:0]  ref_n_o,
  output logic [FB_W-1:0]   fb_n_o,
  output logic              err_o
);
  logic [PB_W:0] pb_ofs;
  logic          out_of_range;

  assign ref_n_o = {1'b0, q_i} + REF_W'(2);
  assign pb_ofs  = {1'b0, pb_i} + (PB_W+1)'(4);
  assign fb_n_o  = {pb_ofs, po_i};

  assign out_of_range = (fb_n_o < FB_W'(FB_MIN)) || (fb_n_o > FB_W'(FB_MAX));
  assign err_o = out_of_range || (pump_i > PUMP_MAX) || (pump_i != pump_need(fb_n_o));
endmodule

// File: rtl/pll_mod_counter.sv
module pll_mod_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;
  logic         at_tc;

  assign at_tc = (cnt_q == '0);

  // ratio sampled only at terminal count: no runt period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= tick_i && at_tc;
      if (tick_i) cnt_q <= at_tc ? ratio_i - W'(1) : cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/pll_div_core.sv
module pll_div_core
  import pll_div_pkg::*;
#(
  parameter logic [9:0] RST_PB   = 10'd4,
  parameter logic       RST_PO   = 1'b0,
  parameter logic [6:0] RST_Q    = 7'd0,
  parameter logic [2:0] RST_PUMP = 3'd0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] rd_sel_i,
  output logic [7:0] rd_data_o,
  input  logic       ref_tick_i,
  input  logic       fb_tick_i,
  output logic       ref_pulse_o,
  output logic       fb_pulse_o,
  output logic       err_o
);
  logic [PB_W-1:0]   pb;
  logic              po;
  logic [Q_W-1:0]    q;
  logic [PUMP_W-1:0] pump;
  logic [REF_W-1:0]  ref_n;
  logic [FB_W-1:0]   fb_n;

  pll_div_regs #(
    .RST_PB(RST_PB), .RST_PO(RST_PO), .RST_Q(RST_Q), .RST_PUMP(RST_PUMP)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .rd_sel_i, .rd_data_o,
    .pb_o(pb), .po_o(po), .q_o(q), .pump_o(pump)
  );

  pll_div_decode u_dec (
    .pb_i(pb), .po_i(po), .q_i(q), .pump_i(pump),
    .ref_n_o(ref_n), .fb_n_o(fb_n), .err_o
  );

  pll_mod_counter #(.W(REF_W)) u_ref_div (
    .clk_i, .rst_ni, .tick_i(ref_tick_i), .ratio_i(ref_n), .pulse_o(ref_pulse_o)
  );

  pll_mod_counter #(.W(FB_W)) u_fb_div (
    .clk_i, .rst_ni, .tick_i(fb_tick_i), .ratio_i(fb_n), .pulse_o(fb_pulse_o)
  );
endmodule

// File: rtl/pll_div_core_chk.sv
module pll_div_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] rd_sel_i,
  input logic [7:0] rd_data_o,
  input logic       ref_tick_i,
  input logic       fb_tick_i,
  input logic       ref_pulse_o,
  input logic       fb_pulse_o,
  input logic       err_o
);
  p_ctl_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 2'd0) |-> (rd_data_o[7:5] == 3'b110));

  p_illegal_pump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 2'd0 && rd_data_o[4:2] > 3'd4) |-> err_o);

  p_ref_needs_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |-> $past(ref_tick_i));

  p_fb_needs_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |-> $past(fb_tick_i));

  p_ref_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |=> !ref_pulse_o);

  p_fb_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o);

  p_sel3_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 2'd3) |-> (rd_data_o == 8'd0));
endmodule

bind pll_div_core pll_div_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
  .ref_tick_i(ref_tick_i), .fb_tick_i(fb_tick_i), .ref_pulse_o(ref_pulse_o),
  .fb_pulse_o(fb_pulse_o), .err_o(err_o)
);

// File: tb/pll_div_core_test.sv
`timescale 1ns/1ps
module pll_div_core_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic [1:0] rd_sel_i = 2'd0;
  logic [7:0] rd_data_o;
  logic       ref_tick_i = 1'b0;
  logic       fb_tick_i = 1'b0;
  logic       ref_pulse_o, fb_pulse_o, err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit ref_half = 1'b0;

  pll_div_core uut (.*);

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_fb(input int pb, input bit po, input int pump);
    logic [9:0] pbv;
    pbv = 10'(pb);
    wr(2'd0, {3'b000, 3'(pump), pbv[9:8]});
    wr(2'd1, pbv[7:0]);
    rd_sel_i = 2'd2;
    #0.1;
    wr(2'd2, {po, rd_data_o[6:0]});
  endtask

  function automatic bit exp_err(input int tot, input int pump);
    int need;
    if (tot < 16 || tot > 1023 || pump > 4) return 1'b1;
    if (tot < 45) need = 0;
    else if (tot < 480) need = 1;
    else if (tot < 640) need = 2;
    else if (tot < 800) need = 3;
    else need = 4;
    return need != pump;
  endfunction

  // waits for a pulse, returns clock cycles to the next one
  task automatic interval(input bit fb, output int n);
    n = 0;
    do @(negedge clk_i); while (!(fb ? fb_pulse_o : ref_pulse_o));
    do begin @(negedge clk_i); n++; end while (!(fb ? fb_pulse_o : ref_pulse_o));
  endtask

  task automatic period(input bit fb, input int exp, input string tag);
    int n;
    interval(fb, n);
    interval(fb, n);
    chk(tag, n, exp);
  endtask

  always @(negedge clk_i) if (ref_half) ref_tick_i <= ~ref_tick_i;

  task automatic t_reset;
    chk("R8 ref_pulse after reset", ref_pulse_o, 0);
    chk("R8 fb_pulse after reset", fb_pulse_o, 0);
    chk("R8 err after reset", err_o, 0);
    rd_sel_i = 2'd0; #0.1; chk("R8 ctl reset value", rd_data_o, 8'hC0);
    rd_sel_i = 2'd1; #0.1; chk("R8 pb low reset value", rd_data_o, 8'd4);
    rd_sel_i = 2'd2; #0.1; chk("R8 po/q reset value", rd_data_o, 8'd0);
    rd_sel_i = 2'd3; #0.1; chk("R9 sel3 reads zero", rd_data_o, 0);
    @(negedge clk_i); ref_tick_i = 1'b1;
    @(negedge clk_i); chk("R8 first tick pulses", ref_pulse_o, 1);
    @(negedge clk_i); chk("R3 pulse one cycle wide", ref_pulse_o, 0);
  endtask

  task automatic t_ref_ratio;
    period(1'b0, 2, "R1 ref ratio Q=0");
    wr(2'd2, 8'h7F);
    period(1'b0, 129, "R1 ref ratio Q=127");
    wr(2'd2, 8'h05);
    period(1'b0, 7, "R1 ref ratio Q=5");
  endtask

  task automatic t_gated;
    ref_tick_i = 1'b0;
    ref_half = 1'b1;
    period(1'b0, 14, "R3 half-rate ticks Q=5");
    ref_half = 1'b0;
    @(negedge clk_i); ref_tick_i = 1'b1;
  endtask

  task automatic t_ratio_change;
    int n;
    wr(2'd2, 8'd18);
    period(1'b0, 20, "R4 old ratio settled");
    do @(negedge clk_i); while (!ref_pulse_o);
    wr_en_i = 1'b1; wr_sel_i = 2'd2; wr_data_i = 8'd3;
    @(negedge clk_i); wr_en_i = 1'b0;
    n = 1;
    while (!ref_pulse_o) begin @(negedge clk_i); n++; end
    chk("R4 running period keeps old ratio", n, 20);
    interval(1'b0, n);
    chk("R4 next period uses new ratio", n, 5);
  endtask

  task automatic t_fb_ratio;
    fb_tick_i = 1'b1;
    period(1'b1, 16, "R2 fb ratio reset 16");
    set_fb(0, 1'b0, 0);
    period(1'b1, 8, "R2 fb ratio min 8");
    chk("R7 total 8 flagged", err_o, 1);
    set_fb(18, 1'b1, 1);
    period(1'b1, 45, "R2 fb ratio odd 45");
    set_fb(1023, 1'b1, 4);
    period(1'b1, 2055, "R2 fb ratio max 2055");
    chk("R7 total 2055 flagged", err_o, 1);
  endtask

  task automatic t_err;
    int pbs[10] = '{18, 18, 235, 236, 315, 316, 395, 396, 507, 508};
    bit pos[10] = '{0, 1, 1, 0, 1, 0, 1, 0, 1, 0};
    for (int i = 0; i < 10; i++) begin
      int tot;
      tot = 2 * (pbs[i] + 4) + pos[i];
      for (int p = 0; p < 5; p++) begin
        set_fb(pbs[i], pos[i], p);
        chk($sformatf("R6 err total %0d pump %0d", tot, p), err_o, exp_err(tot, p));
      end
    end
    set_fb(4, 1'b0, 5);
    chk("R7 pump 101 flagged", err_o, 1);
    set_fb(4, 1'b0, 7);
    chk("R7 pump 111 flagged", err_o, 1);
    wr(2'd0, 8'b0000_1000);
    rd_sel_i = 2'd0; #0.1;
    chk("R5 fixed bits ignore write", rd_data_o, 8'b1100_1000);
    chk("R5 pump field position", rd_data_o[4:2], 3'd2);
    wr(2'd1, 8'hA5);
    rd_sel_i = 2'd1; #0.1;
    chk("R9 pb low readback", rd_data_o, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ref_ratio();
    t_gated();
    t_ratio_change();
    t_fb_ratio();
    t_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule